// File: doc/BRIEF.md
# Bit-Serial Associative Compute Array

This block models an associative compute array of 32 vector elements. Each element sits in one column, and each of its 32 bits sits in its own row. Four metadata rows sit below the data rows: the first is the running carry, and the other three are spare. All arithmetic is done by issuing masked searches and then bulk updates. A search compares every column against a per-row key at the same time and latches one tag bit per column. The update that follows writes a constant into selected rows, but only in the tagged columns.

Metadata rows can take the update in one of two ways. They can be gated by the tags (forwarded gating), which lets a carry flip in the same step as the data bit. Otherwise they are written across every enabled column, which is how a row is initialised in bulk. A column-enable mask shuts disabled columns out of both tagging and updating.

A built-in sequencer adds one to every enabled element when it sees a start pulse. It bulk-sets the carry row, then walks the bits from the lowest up. At each bit it runs the two half-adder search/update pairs that change state. While the sequencer runs, external commands are ignored.

Top module: `assoc_array`

## Requirements
- R1: A search (op_code 1) sets tag bit c to 1 exactly when column c is enabled and, for every row r with op_care[r]=1, the stored bit equals op_key[r]; rows with op_care[r]=0 have no effect.
- R2: A search that cares about more than 4 rows is dropped and leaves the tags unchanged.
- R3: The tags change only on an accepted search; updates and element writes leave them as they were.
- R4: An update (op_code 2) sets each data row r (rows 0 to 31) with op_mask[r]=1 to op_val[r], but only in columns that are both tagged and enabled.
- R5: For a metadata row (rows 32 to 35) with op_mask[r]=1, an update with op_fwd=1 writes only tagged enabled columns, and one with op_fwd=0 writes every enabled column.
- R6: An update that selects more than one data row, or more than one metadata row, is dropped and writes nothing.
- R7: A disabled column (col_en[c]=0) always gets tag 0 from a search, and no update changes its contents.
- R8: After an increment, each enabled element holds its old value plus 1 modulo 2^32. Row 32 of an enabled column holds 1 exactly when the old value was all ones. Disabled columns are untouched.
- R9: inc_busy rises one cycle after an accepted inc_start and stays high for 129 cycles. inc_done rises in the cycle inc_busy falls, and the next accepted start clears it.
- R10: While inc_busy is high, external commands and further inc_start pulses have no effect.
- R11: After reset the tags, every row, inc_busy and inc_done are 0.
- R12: An element write (op_code 3) stores op_word bit i into row i of column op_col, whatever col_en holds. op_code 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| col_en | input | 32 | Per-column enable from the active window |
| op_valid | input | 1 | External command valid |
| op_code | input | 2 | 0 none, 1 search, 2 update, 3 element write |
| op_care | input | 36 | Search: rows that take part |
| op_key | input | 36 | Search: value each cared row must hold |
| op_mask | input | 36 | Update: rows to write |
| op_val | input | 36 | Update: value written to each selected row |
| op_fwd | input | 1 | Update: metadata rows gated by tags when 1 |
| op_col | input | 5 | Element write: column |
| op_word | input | 32 | Element write: data, bit i to row i |
| inc_start | input | 1 | Launch the increment microsequence |
| rd_row | input | 6 | Row to observe |
| rd_bits | output | 32 | Contents of row rd_row, one bit per column |
| tag_out | output | 32 | Latched tag bits |
| inc_busy | output | 1 | Increment in progress |
| inc_done | output | 1 | Increment finished, held until next start |

## Verification
The hardest situation to reach is a column that is tagged but disabled during an update. It needs a search under one enable mask and then an update under a narrower mask. The stimulus searches with col_en at 0x0000FFFF and then updates with col_en at 0x00FF00FF. Only their intersection may change. A second hard case is a command or start pulse landing in the middle of an increment. The bench injects both at a fixed cycle inside the busy window. It then checks that the cycle count and every element are as if nothing had arrived.

// File: rtl/assoc_pkg.sv
package assoc_pkg;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_SEARCH = 2'd1,
    OP_UPDATE = 2'd2,
    OP_WRITE  = 2'd3
  } op_e;

  // number of set bits in a vector of up to 64 rows
  function automatic int ones64(input logic [63:0] v);
    int n;
    n = 0;
    for (int i = 0; i < 64; i++) n += int'(v[i]);
    return n;
  endfunction

  // a search is legal when it engages no more than lim rows
  function automatic bit search_legal(input logic [63:0] care, input int lim);
    return ones64(care) <= lim;
  endfunction

  // an update is legal when each slice gets at most its limit of rows
  function automatic bit update_legal(input logic [63:0] dmask, input logic [63:0] mmask,
                                      input int dlim, input int mlim);
    return (ones64(dmask) <= dlim) && (ones64(mmask) <= mlim);
  endfunction

endpackage

// File: rtl/assoc_match.sv
module assoc_match #(
  parameter int N_ROWS = 36,
  parameter int N_COLS = 32
) (
  input  logic [N_COLS-1:0] rows_i [N_ROWS],
  input  logic [N_ROWS-1:0] care_i,
  input  logic [N_ROWS-1:0] key_i,
  input  logic [N_COLS-1:0] col_en_i,
  output logic [N_COLS-1:0] match_o
);

  for (genvar c = 0; c < N_COLS; c++) begin : g_col
    logic [N_ROWS-1:0] colv;
    always_comb begin
      for (int r = 0; r < N_ROWS; r++) colv[r] = rows_i[r][c];
    end
    assign match_o[c] = col_en_i[c] & ~|(care_i & (colv ^ key_i));
  end

endmodule

// File: rtl/assoc_store.sv
module assoc_store #(
  parameter int N_ROWS = 36,
  parameter int N_COLS = 32,
  parameter int N_DATA = 32,
  localparam int COL_W = $clog2(N_COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [COL_W-1:0]  wr_col,
  input  logic [N_DATA-1:0] wr_word,
  input  logic              upd_en,
  input  logic [N_ROWS-1:0] upd_mask,
  input  logic [N_ROWS-1:0] upd_val,
  input  logic              upd_fwd,
  input  logic [N_COLS-1:0] tag_i,
  input  logic [N_COLS-1:0] col_en_i,
  output logic [N_COLS-1:0] rows_o [N_ROWS]
);

  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    logic [N_COLS-1:0] gate;
    logic [N_COLS-1:0] row_q;

    if (r < N_DATA) begin : g_data
      assign gate = tag_i & col_en_i;
      always_ff @(posedge clk) begin
        if (!rst_n)                      row_q <= '0;
        else if (upd_en && upd_mask[r])  row_q <= upd_val[r] ? (row_q | gate) : (row_q & ~gate);
        else if (wr_en)                  row_q[wr_col] <= wr_word[r];
      end
    end else begin : g_meta
      assign gate = upd_fwd ? (tag_i & col_en_i) : col_en_i;
      always_ff @(posedge clk) begin
        if (!rst_n)                      row_q <= '0;
        else if (upd_en && upd_mask[r])  row_q <= upd_val[r] ? (row_q | gate) : (row_q & ~gate);
      end
    end

    assign rows_o[r] = row_q;
  end

endmodule

// File: rtl/assoc_incr_seq.sv
module assoc_incr_seq
  import assoc_pkg::*;
#(
  parameter int N_DATA    = 32,
  parameter int N_ROWS    = 36,
  parameter int CARRY_ROW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              finish,
  output op_e               cmd_kind,
  output logic [N_ROWS-1:0] cmd_care,
  output logic [N_ROWS-1:0] cmd_key,
  output logic [N_ROWS-1:0] cmd_mask,
  output logic [N_ROWS-1:0] cmd_val,
  output logic              cmd_fwd
);

  localparam int BIT_W = $clog2(N_DATA);
  localparam logic [N_ROWS-1:0] ONE = {{(N_ROWS-1){1'b0}}, 1'b1};

  typedef enum logic [2:0] {SQ_IDLE, SQ_INIT, SQ_S0, SQ_U0, SQ_S1, SQ_U1} sq_e;

  sq_e              state;
  logic [BIT_W-1:0] bitpos;
  logic [N_ROWS-1:0] b_sel;
  logic [N_ROWS-1:0] c_sel;
  logic             last_bit;

  assign last_bit = (bitpos == BIT_W'(N_DATA - 1));
  assign finish   = (state == SQ_U1) && last_bit;
  assign busy     = (state != SQ_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      bitpos <= '0;
      done   <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: if (start) begin
          state  <= SQ_INIT;
          bitpos <= '0;
          done   <= 1'b0;
        end
        SQ_INIT: state <= SQ_S0;
        SQ_S0:   state <= SQ_U0;
        SQ_U0:   state <= SQ_S1;
        SQ_S1:   state <= SQ_U1;
        SQ_U1: begin
          if (last_bit) begin
            state <= SQ_IDLE;
            done  <= 1'b1;
          end else begin
            bitpos <= bitpos + 1'b1;
            state  <= SQ_S0;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    b_sel    = ONE << bitpos;
    c_sel    = ONE << CARRY_ROW;
    cmd_kind = OP_NONE;
    cmd_care = '0;
    cmd_key  = '0;
    cmd_mask = '0;
    cmd_val  = '0;
    cmd_fwd  = 1'b0;
    case (state)
      SQ_INIT: begin            // carry := 1 everywhere enabled
        cmd_kind = OP_UPDATE;
        cmd_mask = c_sel;
        cmd_val  = c_sel;
      end
      SQ_S0: begin              // bit = 0, carry = 1
        cmd_kind = OP_SEARCH;
        cmd_care = b_sel | c_sel;
        cmd_key  = c_sel;
      end
      SQ_U0: begin              // bit := 1, carry := 0
        cmd_kind = OP_UPDATE;
        cmd_mask = b_sel | c_sel;
        cmd_val  = b_sel;
        cmd_fwd  = 1'b1;
      end
      SQ_S1: begin              // bit = 1, carry = 1
        cmd_kind = OP_SEARCH;
        cmd_care = b_sel | c_sel;
        cmd_key  = b_sel | c_sel;
      end
      SQ_U1: begin              // bit := 0, carry := 1
        cmd_kind = OP_UPDATE;
        cmd_mask = b_sel | c_sel;
        cmd_val  = c_sel;
        cmd_fwd  = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/assoc_array.sv
module assoc_array
  import assoc_pkg::*;
#(
  parameter int N_COLS       = 32,
  parameter int N_DATA       = 32,
  parameter int N_META       = 4,
  parameter int MAX_SRCH     = 4,
  parameter int MAX_UPD_DATA = 1,
  parameter int MAX_UPD_META = 1,
  localparam int N_ROWS      = N_DATA + N_META,
  localparam int ROW_W       = $clog2(N_ROWS),
  localparam int COL_W       = $clog2(N_COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_COLS-1:0] col_en,
  input  logic              op_valid,
  input  logic [1:0]        op_code,
  input  logic [N_ROWS-1:0] op_care,
  input  logic [N_ROWS-1:0] op_key,
  input  logic [N_ROWS-1:0] op_mask,
  input  logic [N_ROWS-1:0] op_val,
  input  logic              op_fwd,
  input  logic [COL_W-1:0]  op_col,
  input  logic [N_DATA-1:0] op_word,
  input  logic              inc_start,
  input  logic [ROW_W-1:0]  rd_row,
  output logic [N_COLS-1:0] rd_bits,
  output logic [N_COLS-1:0] tag_out,
  output logic              inc_busy,
  output logic              inc_done
);

  localparam int CARRY_ROW = N_DATA;
  localparam logic [N_ROWS-1:0] DATA_MASK = {{N_META{1'b0}}, {N_DATA{1'b1}}};

  // sequencer command
  op_e               seq_kind;
  logic [N_ROWS-1:0] seq_care, seq_key, seq_mask, seq_val;
  logic              seq_fwd;
  logic              seq_busy;
  logic              seq_finish;

  // selected command
  op_e               cmd_kind;
  logic [N_ROWS-1:0] cmd_care, cmd_key, cmd_mask, cmd_val;
  logic              cmd_fwd;

  // named events for the checker
  logic              search_fire;
  logic              update_fire;
  logic              wr_fire;
  logic              cmd_drop;
  logic              srch_ok;
  logic              upd_ok;

  logic [N_COLS-1:0] rows [N_ROWS];
  logic [N_COLS-1:0] match;
  logic [N_COLS-1:0] tag_q;

  assoc_incr_seq #(
    .N_DATA    (N_DATA),
    .N_ROWS    (N_ROWS),
    .CARRY_ROW (CARRY_ROW)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (inc_start),
    .busy     (seq_busy),
    .done     (inc_done),
    .finish   (seq_finish),
    .cmd_kind (seq_kind),
    .cmd_care (seq_care),
    .cmd_key  (seq_key),
    .cmd_mask (seq_mask),
    .cmd_val  (seq_val),
    .cmd_fwd  (seq_fwd)
  );

  always_comb begin
    if (seq_busy) begin
      cmd_kind = seq_kind;
      cmd_care = seq_care;
      cmd_key  = seq_key;
      cmd_mask = seq_mask;
      cmd_val  = seq_val;
      cmd_fwd  = seq_fwd;
    end else begin
      cmd_kind = op_valid ? op_e'(op_code) : OP_NONE;
      cmd_care = op_care;
      cmd_key  = op_key;
      cmd_mask = op_mask;
      cmd_val  = op_val;
      cmd_fwd  = op_fwd;
    end
  end

  assign srch_ok     = search_legal(64'(cmd_care), MAX_SRCH);
  assign upd_ok      = update_legal(64'(cmd_mask & DATA_MASK), 64'(cmd_mask & ~DATA_MASK),
                                    MAX_UPD_DATA, MAX_UPD_META);
  assign search_fire = (cmd_kind == OP_SEARCH) && srch_ok;
  assign update_fire = (cmd_kind == OP_UPDATE) && upd_ok;
  assign wr_fire     = (cmd_kind == OP_WRITE) && !seq_busy;
  assign cmd_drop    = ((cmd_kind == OP_SEARCH) && !srch_ok) ||
                       ((cmd_kind == OP_UPDATE) && !upd_ok);

  assoc_match #(
    .N_ROWS (N_ROWS),
    .N_COLS (N_COLS)
  ) u_match (
    .rows_i   (rows),
    .care_i   (cmd_care),
    .key_i    (cmd_key),
    .col_en_i (col_en),
    .match_o  (match)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)           tag_q <= '0;
    else if (search_fire) tag_q <= match;
  end

  assoc_store #(
    .N_ROWS (N_ROWS),
    .N_COLS (N_COLS),
    .N_DATA (N_DATA)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_fire),
    .wr_col   (op_col),
    .wr_word  (op_word),
    .upd_en   (update_fire),
    .upd_mask (cmd_mask),
    .upd_val  (cmd_val),
    .upd_fwd  (cmd_fwd),
    .tag_i    (tag_q),
    .col_en_i (col_en),
    .rows_o   (rows)
  );

  assign rd_bits  = (int'(rd_row) < N_ROWS) ? rows[rd_row] : '0;
  assign tag_out  = tag_q;
  assign inc_busy = seq_busy;

endmodule

// File: rtl/assoc_array_chk.sv
module assoc_array_chk #(
  parameter int N_COLS = 32,
  parameter int ROW_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_COLS-1:0] col_en,
  input logic [N_COLS-1:0] tag_out,
  input logic [ROW_W-1:0]  rd_row,
  input logic [N_COLS-1:0] rd_bits,
  input logic              inc_start,
  input logic              inc_busy,
  input logic              inc_done,
  input logic              search_fire,
  input logic              wr_fire,
  input logic              cmd_drop,
  input logic              seq_finish
);

  AST_TAG_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    search_fire |=> ((tag_out & ~$past(col_en)) == '0)); // R7

  AST_TAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !search_fire |=> $stable(tag_out)); // R3

  AST_DROP_KEEPS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_drop |=> $stable(tag_out)); // R2

  AST_DISABLED_COL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> ((rd_row != $past(rd_row)) ||
                  (((rd_bits ^ $past(rd_bits)) & ~$past(col_en)) == '0))); // R7

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_start && !inc_busy) |=> (inc_busy && !inc_done)); // R9

  AST_DONE_WITH_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inc_done) |-> $fell(inc_busy)); // R9

  AST_FINISH_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    seq_finish |=> (!inc_busy && inc_done)); // R9

  AST_SEQ_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    inc_busy |-> !cmd_drop); // R8

endmodule

bind assoc_array assoc_array_chk #(
  .N_COLS (N_COLS),
  .ROW_W  (ROW_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .col_en      (col_en),
  .tag_out     (tag_out),
  .rd_row      (rd_row),
  .rd_bits     (rd_bits),
  .inc_start   (inc_start),
  .inc_busy    (inc_busy),
  .inc_done    (inc_done),
  .search_fire (search_fire),
  .wr_fire     (wr_fire),
  .cmd_drop    (cmd_drop),
  .seq_finish  (seq_finish)
);

// File: tb/assoc_array_tb.sv
`timescale 1ns/1ps
module assoc_array_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] col_en;
  logic        op_valid;
  logic [1:0]  op_code;
  logic [35:0] op_care, op_key, op_mask, op_val;
  logic        op_fwd;
  logic [4:0]  op_col;
  logic [31:0] op_word;
  logic        inc_start;
  logic [5:0]  rd_row;
  logic [31:0] rd_bits;
  logic [31:0] tag_out;
  logic        inc_busy;
  logic        inc_done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [31:0] got [32];

  always #4 clk = ~clk;

  assoc_array dut_i (
    .clk(clk), .rst_n(rst_n), .col_en(col_en), .op_valid(op_valid), .op_code(op_code),
    .op_care(op_care), .op_key(op_key), .op_mask(op_mask), .op_val(op_val), .op_fwd(op_fwd),
    .op_col(op_col), .op_word(op_word), .inc_start(inc_start), .rd_row(rd_row),
    .rd_bits(rd_bits), .tag_out(tag_out), .inc_busy(inc_busy), .inc_done(inc_done)
  );

  // {col_en, seed}
  localparam logic [63:0] VEC_TAB [8] = '{
    {32'hFFFFFFFF, 32'h00000000},
    {32'hFFFFFFFF, 32'hFFFF0000},
    {32'h0F0F0F0F, 32'h12345678},
    {32'hFFFFFFFE, 32'hA5A5A5A5},
    {32'h00000000, 32'h00000001},
    {32'h80000001, 32'hDEADBEEF},
    {32'hFFFFFFFF, 32'hFFFFFFFF},
    {32'h55555555, 32'h00FF00FF}
  };

  function automatic logic [31:0] elem_of(input logic [31:0] seed, input int c);
    if (c == 0) return 32'hFFFFFFFF;
    if (c == 1) return 32'h00000000;
    if (c == 2) return 32'h7FFFFFFF;
    if (c == 3) return 32'h0000FFFF;
    return seed ^ (32'(c) * 32'h9E3779B9);
  endfunction

  function automatic logic [35:0] rbit(input int r);
    return 36'(1) << r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [1:0] code, input logic [35:0] care, input logic [35:0] key,
                       input logic [35:0] mask, input logic [35:0] val, input logic fwd,
                       input int col, input logic [31:0] word);
    op_valid = 1'b1; op_code = code; op_care = care; op_key = key;
    op_mask = mask; op_val = val; op_fwd = fwd; op_col = 5'(col); op_word = word;
    @(negedge clk);
    op_valid = 1'b0; op_code = 2'd0;
  endtask

  task automatic search(input logic [35:0] care, input logic [35:0] key);
    do_op(2'd1, care, key, '0, '0, 1'b0, 0, '0);
  endtask

  task automatic update(input logic [35:0] mask, input logic [35:0] val, input logic fwd);
    do_op(2'd2, '0, '0, mask, val, fwd, 0, '0);
  endtask

  task automatic write_elem(input int c, input logic [31:0] w);
    do_op(2'd3, '0, '0, '0, '0, 1'b0, c, w);
  endtask

  task automatic read_row(input int r, output logic [31:0] bits);
    rd_row = 6'(r);
    #1;
    bits = rd_bits;
  endtask

  task automatic read_elems();
    logic [31:0] rb;
    for (int r = 0; r < 32; r++) begin
      read_row(r, rb);
      for (int c = 0; c < 32; c++) got[c][r] = rb[c];
    end
    @(negedge clk);
  endtask

  task automatic check_row(input string req, input int r, input logic [31:0] exp);
    logic [31:0] rb;
    read_row(r, rb);
    check(req, rb, exp);
  endtask

  task automatic run_inc(output int cyc);
    inc_start = 1'b1;
    @(negedge clk);
    inc_start = 1'b0;
    cyc = 0;
    while (inc_busy && cyc < 1000) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp_carry;
    logic [31:0] v;
    logic [31:0] rb;
    logic [31:0] exp_tag;
    int cyc;

    rst_n = 1'b0; col_en = '1; op_valid = 1'b0; op_code = 2'd0; op_care = '0; op_key = '0;
    op_mask = '0; op_val = '0; op_fwd = 1'b0; op_col = '0; op_word = '0; inc_start = 1'b0;
    rd_row = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset state
    check("R11 tag", tag_out, 32'h0);
    check("R11 busy", {31'h0, inc_busy}, 32'h0);
    check("R11 done", {31'h0, inc_done}, 32'h0);
    check_row("R11 row0", 0, 32'h0);
    check_row("R11 row35", 35, 32'h0);
    @(negedge clk);

    // table of increment vectors (R8, R9, R7, R12)
    exp_carry = '0;
    for (int k = 0; k < 8; k++) begin
      col_en = VEC_TAB[k][63:32];
      for (int c = 0; c < 32; c++) write_elem(c, elem_of(VEC_TAB[k][31:0], c));
      run_inc(cyc);
      check("R9 busy length", 32'(cyc), 32'd129);
      check("R9 done raised", {31'h0, inc_done}, 32'h1);
      read_elems();
      for (int c = 0; c < 32; c++) begin
        v = elem_of(VEC_TAB[k][31:0], c);
        if (col_en[c]) begin
          check("R8 element", got[c], v + 32'd1);
          exp_carry[c] = (v == 32'hFFFFFFFF);
        end else begin
          check("R7 element untouched", got[c], v);
        end
      end
      check_row("R8 carry row", 32, exp_carry);
      @(negedge clk);
    end

    // directed: search and update
    col_en = '1;
    for (int c = 0; c < 32; c++) write_elem(c, 32'(c));

    search(36'h3, 36'h1);                                  // R1: low two bits == 01
    exp_tag = '0;
    for (int c = 0; c < 32; c++) exp_tag[c] = ((c & 3) == 1);
    check("R1 search low bits", tag_out, exp_tag);

    search(rbit(4) | rbit(35), rbit(4));                   // R1: bit4=1, row35=0
    check("R1 search bit4", tag_out, 32'hFFFF0000);

    search(36'h1F, 36'h0);                                 // R2: five rows -> dropped
    check("R2 search over limit", tag_out, 32'hFFFF0000);

    write_elem(0, 32'h10);                                 // R3, R12
    check("R3 tag after write", tag_out, 32'hFFFF0000);

    search(36'h3, 36'h1);
    update(rbit(4), rbit(4), 1'b0);                        // R4
    check_row("R4 data row updated", 4, 32'hFFFF2223);
    check_row("R4 other row untouched", 0, 32'hAAAAAAAA);
    check("R3 tag after update", tag_out, 32'h22222222);
    @(negedge clk);

    update(rbit(33), rbit(33), 1'b1);                      // R5 gated by tags
    check_row("R5 meta forwarded", 33, 32'h22222222);
    @(negedge clk);
    update(rbit(34), rbit(34), 1'b0);                      // R5 bulk
    check_row("R5 meta bulk", 34, 32'hFFFFFFFF);
    @(negedge clk);

    update(rbit(5) | rbit(6), rbit(5) | rbit(6), 1'b0);    // R6 two data rows
    check_row("R6 row5 kept", 5, 32'h0);
    check_row("R6 row6 kept", 6, 32'h0);
    @(negedge clk);
    update(rbit(33) | rbit(34), 36'h0, 1'b0);              // R6 two meta rows
    check_row("R6 row33 kept", 33, 32'h22222222);
    check_row("R6 row34 kept", 34, 32'hFFFFFFFF);
    @(negedge clk);

    col_en = 32'h0000FFFF;                                 // R7
    search(36'h0, 36'h0);
    check("R7 tag masked", tag_out, 32'h0000FFFF);
    update(rbit(35), rbit(35), 1'b0);
    check_row("R7 bulk meta masked", 35, 32'h0000FFFF);
    @(negedge clk);
    col_en = 32'h00FF00FF;
    update(rbit(8), rbit(8), 1'b1);
    check_row("R7 tagged but disabled", 8, 32'h000000FF);
    @(negedge clk);

    col_en = 32'h0;                                        // R12: write ignores col_en
    write_elem(9, 32'hCAFEF00D);
    op_valid = 1'b1; op_code = 2'd0; op_word = 32'hFFFFFFFF; op_col = 5'd9;
    @(negedge clk);                                        // R12: code 0 does nothing
    op_valid = 1'b0;
    read_elems();
    check("R12 element write", got[9], 32'hCAFEF00D);

    // R10: commands and starts during busy are ignored
    col_en = '1;
    for (int c = 0; c < 32; c++) write_elem(c, 32'(c * 3));
    inc_start = 1'b1;
    @(negedge clk);
    inc_start = 1'b0;
    cyc = 0;
    while (inc_busy && cyc < 1000) begin
      if (cyc == 5) begin
        op_valid = 1'b1; op_code = 2'd3; op_col = 5'd2; op_word = 32'h0; inc_start = 1'b1;
      end else begin
        op_valid = 1'b0; op_code = 2'd0; inc_start = 1'b0;
      end
      cyc++;
      @(negedge clk);
    end
    op_valid = 1'b0; inc_start = 1'b0;
    check("R10 busy length", 32'(cyc), 32'd129);
    @(negedge clk);
    check("R10 no restart", {31'h0, inc_busy}, 32'h0);
    read_elems();
    check("R10 col2", got[2], 32'd7);
    check("R10 col31", got[31], 32'd94);

    // R9: next start clears done
    inc_start = 1'b1;
    @(negedge clk);
    inc_start = 1'b0;
    check("R9 done cleared", {31'h0, inc_done}, 32'h0);
    check("R9 busy raised", {31'h0, inc_busy}, 32'h1);
    cyc = 0;
    while (inc_busy && cyc < 1000) begin cyc++; @(negedge clk); end
    read_elems();
    check("R8 second increment", got[10], 32'd32);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule